// File: doc/BRIEF.md
# FIFO Threshold and Draining Event Generator

This block sits beside the transmit and receive FIFOs of an I2C controller. It decides when software should be told that the FIFOs need servicing. It tracks how many bytes of the current transfer are still to move: a remaining-byte counter is loaded with the programmed transfer length at start and counts down on each byte the serial engine moves. The counter is compared, together with the live FIFO levels, against the two programmed thresholds.

Four events come out as single-cycle pulses toward a status register:

| Bit | Event | Meaning |
|-----|-------|---------|
| 0 | transmit-ready | the transmit FIFO has room for a full threshold's worth of bytes |
| 1 | transmit-drain | the transmit FIFO has room, but fewer than a threshold's worth of bytes are still to be supplied |
| 2 | receive-ready | the receive FIFO holds at least a threshold's worth of bytes |
| 3 | receive-drain | the transfer has finished and a short tail, below the threshold, is left in the receive FIFO |

Each event fires once and then waits to be re-armed by software before it can fire again. A write to the buffer configuration word sets both thresholds and can also request one-cycle FIFO clear strobes.

A small state machine controls the transfer. It has four states:

- ST_IDLE: no transfer. It moves to ST_TX or ST_RX on an accepted start.
- ST_TX: transmitting. It returns to ST_IDLE when the last byte moves.
- ST_RX: receiving. It moves to ST_RX_DRAIN when the last byte arrives.
- ST_RX_DRAIN: the transfer is over and the receive FIFO still holds data. It returns to ST_IDLE once the receive FIFO level reads zero.

Top module: `i2c_fifo_event_gen`

## Requirements
- R1: Configuration word layout. The transmit threshold field is bits [5:0] and the receive threshold field is bits [13:8]. Each field holds the threshold minus one, so the effective threshold runs from 1 to 64. The reset value of both fields is 0, which gives a threshold of 1.
- R2: Receive-ready (evt_pulse_o bit 2) fires while the state is ST_RX or ST_RX_DRAIN and the receive level is at or above the receive threshold.
- R3: Receive-drain (evt_pulse_o bit 3) fires only in ST_RX_DRAIN, when the receive level is nonzero and below the receive threshold.
- R4: Transmit-ready (evt_pulse_o bit 0) fires in ST_TX when the transmit level is below the transmit threshold and the bytes still to be supplied (remaining minus transmit level, floored at 0) are at least the threshold.
- R5: Transmit-drain (evt_pulse_o bit 1) fires in ST_TX when the transmit level is below the threshold and the bytes still to be supplied are nonzero and below the threshold. It never fires in the same cycle as transmit-ready.
- R6: Counter and state transitions.
  - The remaining-byte counter loads the transfer length on an accepted start.
  - It decrements on each byte_done_i while in ST_TX or ST_RX.
  - ST_TX returns to ST_IDLE on its last byte.
  - ST_RX enters ST_RX_DRAIN on its last byte.
  - ST_RX_DRAIN returns to ST_IDLE when the receive level is 0.
- R7: A start is ignored in two cases: when the length is zero, and when a transfer is already in progress.
- R8: Writing 1 to bit 6 of the configuration word produces a one-cycle tx_fifo_clr_o pulse in the cycle after the write. Writing 1 to bit 14 does the same for rx_fifo_clr_o. Neither bit is stored.
- R9: Each event pulses for one cycle and is then disarmed. Writing 1 to its bit of evt_rearm_i re-arms it, and it fires again one cycle later if its condition still holds. A firing in the same cycle as a re-arm leaves the event disarmed.
- R10: Events follow direction and activity. In ST_IDLE no event fires. Transmit events never fire during a receive, and receive events never fire during a transmit.
- R11: depth_code_o reports the parameter DEPTH_CODE n, where the FIFO depth is 8 << n.
- R12: During and right after reset, all event pulses and clear strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the buffer configuration word |
| cfg_wdata_i | input | 16 | Configuration data: thresholds and clear bits |
| xfer_len_i | input | CNT_W | Transfer length in bytes |
| xfer_start_i | input | 1 | Start a transfer |
| xfer_dir_rx_i | input | 1 | 1 = receive, 0 = transmit |
| byte_done_i | input | 1 | The serial engine moved one byte |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| evt_rearm_i | input | 4 | Write-1 re-arm, one bit per event |
| evt_pulse_o | output | 4 | Event pulses: 0 tx-ready, 1 tx-drain, 2 rx-ready, 3 rx-drain |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear strobe |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear strobe |
| depth_code_o | output | DC_W | FIFO depth exponent |

## Verification
The bench uses the default build: DEPTH_CODE = 0 (an 8-entry FIFO, 4-bit levels) and a 16-bit counter.

- Transmit sweep: every threshold from 1 to 8, combined with every transfer length from 1 to 10 and every transmit level from 0 to 8. This covers every crossing between level, pending bytes and threshold.
- Receive sweep: every threshold against every level, once in ST_RX and once in ST_RX_DRAIN.
- Threshold boundary: a threshold of 64 probes the top of the field range.

In each sweep the unused direction is driven to a level that would wrongly trigger its own events.

// File: rtl/i2c_fev_pkg.sv
package i2c_fev_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_TX       = 2'd1,
        ST_RX       = 2'd2,
        ST_RX_DRAIN = 2'd3
    } xfer_state_e;

    localparam int EV_TX_READY = 0;
    localparam int EV_TX_DRAIN = 1;
    localparam int EV_RX_READY = 2;
    localparam int EV_RX_DRAIN = 3;
    localparam int EV_NUM      = 4;

    localparam int CFG_W      = 16;
    localparam int THR_FLD_W  = 6;
    localparam int TX_THR_LSB = 0;
    localparam int TX_CLR_BIT = 6;
    localparam int RX_THR_LSB = 8;
    localparam int RX_CLR_BIT = 14;

endpackage

// File: rtl/fev_cfg_reg.sv
module fev_cfg_reg
    import i2c_fev_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_wr_i,
    input  logic [CFG_W-1:0]     cfg_wdata_i,
    output logic [THR_FLD_W:0]   tx_thr_o,
    output logic [THR_FLD_W:0]   rx_thr_o,
    output logic                 tx_fifo_clr_o,
    output logic                 rx_fifo_clr_o
);

    logic [THR_FLD_W-1:0] tx_fld_q, rx_fld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_fld_q      <= '0;
            rx_fld_q      <= '0;
            tx_fifo_clr_o <= 1'b0;
            rx_fifo_clr_o <= 1'b0;
        end else begin
            tx_fifo_clr_o <= cfg_wr_i & cfg_wdata_i[TX_CLR_BIT];
            rx_fifo_clr_o <= cfg_wr_i & cfg_wdata_i[RX_CLR_BIT];
            if (cfg_wr_i) begin
                tx_fld_q <= cfg_wdata_i[TX_THR_LSB +: THR_FLD_W];
                rx_fld_q <= cfg_wdata_i[RX_THR_LSB +: THR_FLD_W];
            end
        end
    end

    // Effective threshold is the stored field plus one.
    assign tx_thr_o = {1'b0, tx_fld_q} + 1'b1;
    assign rx_thr_o = {1'b0, rx_fld_q} + 1'b1;

    p_tx_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_fifo_clr_o |-> $past(cfg_wr_i && cfg_wdata_i[TX_CLR_BIT]));
    p_rx_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_fifo_clr_o |-> $past(cfg_wr_i && cfg_wdata_i[RX_CLR_BIT]));

endmodule

// File: rtl/fev_xfer_fsm.sv
module fev_xfer_fsm
    import i2c_fev_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dir_rx_i,
    input  logic             byte_i,
    input  logic [LVL_W-1:0] rx_level_i,
    output xfer_state_e      state_o,
    output logic [CNT_W-1:0] remain_o
);

    xfer_state_e state_q, state_d;
    logic        accept;
    logic        last_byte;

    assign accept    = (state_q == ST_IDLE) && start_i && (len_i != '0);
    assign last_byte = byte_i && (remain_o == CNT_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = dir_rx_i ? ST_RX : ST_TX;
            ST_TX:       if (last_byte) state_d = ST_IDLE;
            ST_RX:       if (last_byte) state_d = ST_RX_DRAIN;
            ST_RX_DRAIN: if (rx_level_i == '0) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            remain_o <= '0;
        end else if (accept) begin
            remain_o <= len_i;
        end else if ((state_q == ST_TX || state_q == ST_RX) && byte_i && remain_o != '0) begin
            remain_o <= remain_o - 1'b1;
        end
    end

    assign state_o = state_q;

    p_zero_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && start_i && len_i == '0) |=> state_q == ST_IDLE);
    p_busy_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && start_i && !byte_i) |=> remain_o == $past(remain_o));
    p_count_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_TX || state_q == ST_RX) && byte_i && remain_o != '0)
        |=> remain_o == $past(remain_o) - 1'b1);

endmodule

// File: rtl/fev_cond.sv
module fev_cond
    import i2c_fev_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input  xfer_state_e        state_i,
    input  logic [CNT_W-1:0]   remain_i,
    input  logic [LVL_W-1:0]   tx_level_i,
    input  logic [LVL_W-1:0]   rx_level_i,
    input  logic [THR_FLD_W:0] tx_thr_i,
    input  logic [THR_FLD_W:0] rx_thr_i,
    output logic [EV_NUM-1:0]  cond_o
);

    localparam int CMP_W = ((CNT_W > THR_FLD_W + 1) ? CNT_W : THR_FLD_W + 1) + 1;

    logic [CMP_W-1:0] rem_x, txl_x, rxl_x, txt_x, rxt_x, pend_x;
    logic             tx_room;

    always_comb begin
        rem_x   = CMP_W'(remain_i);
        txl_x   = CMP_W'(tx_level_i);
        rxl_x   = CMP_W'(rx_level_i);
        txt_x   = CMP_W'(tx_thr_i);
        rxt_x   = CMP_W'(rx_thr_i);
        pend_x  = (rem_x > txl_x) ? rem_x - txl_x : '0;
        tx_room = txl_x < txt_x;
        cond_o  = '0;
        unique case (state_i)
            ST_TX: begin
                cond_o[EV_TX_READY] = tx_room && (pend_x >= txt_x);
                cond_o[EV_TX_DRAIN] = tx_room && (pend_x != '0) && (pend_x < txt_x);
            end
            ST_RX: begin
                cond_o[EV_RX_READY] = rxl_x >= rxt_x;
            end
            ST_RX_DRAIN: begin
                cond_o[EV_RX_READY] = rxl_x >= rxt_x;
                cond_o[EV_RX_DRAIN] = (rxl_x != '0) && (rxl_x < rxt_x);
            end
            default: cond_o = '0;
        endcase
    end

endmodule

// File: rtl/fev_event_arm.sv
module fev_event_arm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cond_i,
    input  logic rearm_i,
    output logic pulse_o
);

    logic armed_q;
    logic fire;

    assign fire = cond_i && armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b1;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire;
            if (fire)         armed_q <= 1'b0;
            else if (rearm_i) armed_q <= 1'b1;
        end
    end

    p_one_shot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/i2c_fifo_event_gen.sv
module i2c_fifo_event_gen
    import i2c_fev_pkg::*;
#(
    parameter int DEPTH_CODE = 0,
    parameter int CNT_W      = 16,
    localparam int DC_W      = 2,
    localparam int DEPTH     = 8 << DEPTH_CODE,
    localparam int LVL_W     = $clog2(DEPTH) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [15:0]       cfg_wdata_i,
    input  logic [CNT_W-1:0]  xfer_len_i,
    input  logic              xfer_start_i,
    input  logic              xfer_dir_rx_i,
    input  logic              byte_done_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic [3:0]        evt_rearm_i,
    output logic [3:0]        evt_pulse_o,
    output logic              tx_fifo_clr_o,
    output logic              rx_fifo_clr_o,
    output logic [DC_W-1:0]   depth_code_o
);

    logic [THR_FLD_W:0] tx_thr, rx_thr;
    xfer_state_e        state;
    logic [CNT_W-1:0]   remain;
    logic [EV_NUM-1:0]  cond;

    fev_cfg_reg u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .tx_thr_o     (tx_thr),
        .rx_thr_o     (rx_thr),
        .tx_fifo_clr_o(tx_fifo_clr_o),
        .rx_fifo_clr_o(rx_fifo_clr_o)
    );

    fev_xfer_fsm #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (xfer_start_i),
        .len_i     (xfer_len_i),
        .dir_rx_i  (xfer_dir_rx_i),
        .byte_i    (byte_done_i),
        .rx_level_i(rx_level_i),
        .state_o   (state),
        .remain_o  (remain)
    );

    fev_cond #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_cond (
        .state_i   (state),
        .remain_i  (remain),
        .tx_level_i(tx_level_i),
        .rx_level_i(rx_level_i),
        .tx_thr_i  (tx_thr),
        .rx_thr_i  (rx_thr),
        .cond_o    (cond)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_evt
        fev_event_arm u_arm (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cond_i (cond[g]),
            .rearm_i(evt_rearm_i[g]),
            .pulse_o(evt_pulse_o[g])
        );
    end

    assign depth_code_o = DC_W'(DEPTH_CODE);

    p_tx_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(evt_pulse_o[EV_TX_READY] && evt_pulse_o[EV_TX_DRAIN]));
    p_dir_split_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((evt_pulse_o[EV_TX_READY] || evt_pulse_o[EV_TX_DRAIN]) &&
          (evt_pulse_o[EV_RX_READY] || evt_pulse_o[EV_RX_DRAIN])));
    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state) == ST_IDLE) |-> evt_pulse_o == '0);

endmodule

// File: tb/i2c_fifo_event_gen_tb.sv
module i2c_fifo_event_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] xlen = '0;
    logic        xstart = 1'b0;
    logic        xdir = 1'b0;
    logic        bdone = 1'b0;
    logic [3:0]  txl = '0;
    logic [3:0]  rxl = '0;
    logic [3:0]  rearm = '0;
    logic [3:0]  evt;
    logic        txclr, rxclr;
    logic [1:0]  dcode;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_fifo_event_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
        .xfer_len_i(xlen), .xfer_start_i(xstart), .xfer_dir_rx_i(xdir),
        .byte_done_i(bdone), .tx_level_i(txl), .rx_level_i(rxl),
        .evt_rearm_i(rearm), .evt_pulse_o(evt), .tx_fifo_clr_o(txclr),
        .rx_fifo_clr_o(rxclr), .depth_code_o(dcode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int tthr, input int rthr, input bit tclr, input bit rclr);
        cfg_wdata = 16'((tthr - 1) & 63) | (16'((rthr - 1) & 63) << 8)
                  | (16'(tclr) << 6) | (16'(rclr) << 14);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start(input int len, input bit rx);
        xlen = 16'(len); xdir = rx; xstart = 1'b1;
        @(negedge clk);
        xstart = 1'b0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            bdone = 1'b1;
            @(negedge clk);
            bdone = 1'b0;
        end
    endtask

    // Re-arm all events once, then OR the pulses seen over four cycles.
    task automatic win(input logic [3:0] exp, input string req);
        logic [3:0] acc;
        rearm = 4'hF;
        @(negedge clk);
        acc = evt;
        rearm = 4'h0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acc |= evt;
        end
        chk(acc == exp, req, int'(acc), int'(exp));
    endtask

    initial begin
        int cnt;
        logic [3:0] e;
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(evt == 4'h0 && !txclr && !rxclr, "R12 in reset", int'(evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(evt == 4'h0 && !txclr && !rxclr, "R12 after reset", int'(evt), 0);
        chk(dcode == 2'd0, "R11 depth code", int'(dcode), 0);

        // R4 R5 R1 R10: transmit sweep
        for (int thr = 1; thr <= 8; thr++) begin
            cfg(thr, thr, 0, 0);
            for (int len = 1; len <= 10; len++) begin
                start(len, 1'b0);
                rxl = 4'd8;
                for (int lv = 0; lv <= 8; lv++) begin
                    int pend;
                    txl = 4'(lv);
                    pend = (len > lv) ? len - lv : 0;
                    e = '0;
                    e[0] = (lv < thr) && (pend >= thr);
                    e[1] = (lv < thr) && (pend != 0) && (pend < thr);
                    win(e, "R4/R5 tx sweep");
                end
                rxl = 4'd0;
                bytes(len);
            end
        end

        // R2 R3 R6 R10: receive sweep
        for (int thr = 1; thr <= 8; thr++) begin
            cfg(thr, thr, 0, 0);
            txl = 4'd0;
            start(3, 1'b1);
            for (int lv = 0; lv <= 8; lv++) begin
                rxl = 4'(lv);
                e = '0;
                e[2] = (lv >= thr);
                win(e, "R2 rx running");
            end
            rxl = 4'd1;
            bytes(3);
            for (int lv = 8; lv >= 1; lv--) begin
                rxl = 4'(lv);
                e = '0;
                e[2] = (lv >= thr);
                e[3] = (lv < thr);
                win(e, "R3 rx drain");
            end
            rxl = 4'd0;
            win(4'h0, "R6 drain empty");
            rxl = 4'd8;
            txl = 4'd0;
            win(4'h0, "R6 idle after drain");
            rxl = 4'd0;
        end

        // R1: top of threshold range (64)
        cfg(64, 64, 0, 0);
        txl = 4'd0;
        start(100, 1'b0);
        win(4'b0001, "R1 thr64 ready");
        bytes(37);
        win(4'b0010, "R1 thr64 drain");
        bytes(63);
        win(4'h0, "R6 tx done idle");

        // R6: countdown moves tx from ready to drain
        cfg(4, 4, 0, 0);
        start(6, 1'b0);
        win(4'b0001, "R6 loaded");
        bytes(3);
        win(4'b0010, "R6 after 3 bytes");
        bytes(3);
        win(4'h0, "R6 back to idle");

        // R7: zero length and busy start
        start(0, 1'b0);
        win(4'h0, "R7 zero length");
        start(5, 1'b0);
        start(1, 1'b1);
        win(4'b0001, "R7 busy start ignored");

        // R9: one pulse per arming
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cnt += int'(evt[0]);
        end
        chk(cnt == 0, "R9 no repeat without rearm", cnt, 0);
        rearm = 4'b0001;
        @(negedge clk);
        cnt = int'(evt[0]);
        rearm = 4'h0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cnt += int'(evt[0]);
        end
        chk(cnt == 1, "R9 single pulse after rearm", cnt, 1);
        bytes(5);

        // R8: clear strobes
        cfg(4, 4, 1, 1);
        chk(txclr && rxclr, "R8 both clears", int'({txclr, rxclr}), 3);
        @(negedge clk);
        chk(!txclr && !rxclr, "R8 clears one cycle", int'({txclr, rxclr}), 0);
        cfg(4, 4, 1, 0);
        chk(txclr && !rxclr, "R8 tx clear only", int'({txclr, rxclr}), 2);
        cfg(4, 4, 0, 1);
        chk(!txclr && rxclr, "R8 rx clear only", int'({txclr, rxclr}), 1);
        start(4, 1'b0);
        win(4'b0001, "R8 threshold kept with clear");
        bytes(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule